// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address for a 32-bit fetch stage. Every cycle the fetch stage presents its current address. A combinational lookup into a direct-mapped table returns a predicted next address. On a hit this is the stored target. On a miss it is the sequential address. The block also returns an info word, which is the looked-up fetch address itself. The pipeline carries that word alongside the instruction.

Once the real next address is known, the pipeline hands the info word back on the training port. It also supplies a flag saying whether the prediction was correct, and the resolved next address. The row index and the tag are both rebuilt from the info word, so training needs no second lookup. Only mispredictions write the table.

Training and prediction run side by side in the same cycle. A write lands at the clock edge, so the lookup in that cycle still sees the old row and the next cycle sees the new one.

Top module: `btb_predictor`

## Requirements
- R1: After reset every row is invalid, so every lookup returns fetch address + 4 until some row has been trained.
- R2: The row used by a lookup or a training is selected by address bits [7:2] (address shifted right by two, low 6 bits), giving 64 rows.
- R3: A hit requires the row to be valid and its stored tag to equal the full 32-bit fetch address; a different address that maps to the same row misses.
- R4: On a hit the predicted next address is the target stored in that row.
- R5: On a miss the predicted next address is the fetch address + 4, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R6: The info word output always equals the fetch address being looked up.
- R7: A training request (trn_valid = 1) with trn_correct = 0 writes tag = trn_info, target = trn_target and valid into the row selected by trn_info.
- R8: A training request with trn_correct = 1 leaves the table unchanged.
- R9: A training write is not visible to the lookup in its own cycle and is visible from the next cycle on.
- R10: Training a row that holds another address replaces it, so the earlier address misses afterwards.
- R11: With trn_valid = 0 the training inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid bits |
| fetch_pc | input | 32 | Current fetch address to look up |
| pred_next | output | 32 | Predicted next fetch address |
| pred_info | output | 32 | Info word to carry with the instruction (the fetch address) |
| trn_valid | input | 1 | Training request this cycle |
| trn_info | input | 32 | Info word returned by the pipeline |
| trn_correct | input | 1 | 1 when the earlier prediction was right |
| trn_target | input | 32 | Resolved next address |

## Verification
Prediction and training can fall in the same cycle, including on the very row being trained. The bench provokes this in directed steps that train an address while looking it up. It also drives random cycles where training and lookup addresses share a small pool, so row collisions are frequent. The bench judges each such cycle against a model. That model updates only at the clock edge, so the lookup in the training cycle must show the old row and the following cycle must show the new one.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int unsigned BTB_ADDR_W = 32;
    localparam int unsigned BTB_STEP   = 4;

    typedef logic [BTB_ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        addr_t tag;
        addr_t target;
    } btb_row_t;

endpackage

// File: rtl/btb_index.sv
module btb_index
    import btb_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int SHIFT = 2,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  addr_t            addr,
    output logic [IDX_W-1:0] idx
);

    // Row select: word address, truncated to the table size.
    always_comb begin
        idx = addr[SHIFT +: IDX_W];
    end

endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ROWS = 64,
    localparam int IDX_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output btb_row_t         rd_row,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  addr_t            wr_tag,
    input  addr_t            wr_target
);

    logic  valid_q  [ROWS];
    addr_t tag_q    [ROWS];
    addr_t target_q [ROWS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            logic hit_wr;

            always_comb begin
                hit_wr = wr_en && (wr_idx == IDX_W'(r));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q[r] <= 1'b0;
                end else if (hit_wr) begin
                    valid_q[r] <= 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (hit_wr) begin
                    tag_q[r]    <= wr_tag;
                    target_q[r] <= wr_target;
                end
            end
        end
    endgenerate

    // Read port is combinational: a write shows up after the edge.
    always_comb begin
        rd_row.valid  = valid_q[rd_idx];
        rd_row.tag    = tag_q[rd_idx];
        rd_row.target = target_q[rd_idx];
    end

endmodule

// File: rtl/btb_match.sv
module btb_match
    import btb_pkg::*;
(
    input  addr_t    pc,
    input  btb_row_t row,
    output addr_t    next_pc
);

    logic  tag_eq;
    addr_t seq_pc;

    always_comb begin
        tag_eq  = row.valid && (row.tag == pc);
        seq_pc  = pc + addr_t'(BTB_STEP);
        next_pc = tag_eq ? row.target : seq_pc;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ROWS  = 64,
    parameter int SHIFT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] fetch_pc,
    output logic [31:0] pred_next,
    output logic [31:0] pred_info,
    input  logic        trn_valid,
    input  logic [31:0] trn_info,
    input  logic        trn_correct,
    input  logic [31:0] trn_target
);

    localparam int IDX_W = $clog2(ROWS);

    logic [IDX_W-1:0] look_idx;
    logic [IDX_W-1:0] train_idx;
    btb_row_t         look_row;
    logic             train_wr;

    btb_index #(.ROWS(ROWS), .SHIFT(SHIFT)) u_look_idx (
        .addr (fetch_pc),
        .idx  (look_idx)
    );

    btb_index #(.ROWS(ROWS), .SHIFT(SHIFT)) u_train_idx (
        .addr (trn_info),
        .idx  (train_idx)
    );

    always_comb begin
        train_wr = trn_valid && !trn_correct;
    end

    btb_store #(.ROWS(ROWS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (look_idx),
        .rd_row    (look_row),
        .wr_en     (train_wr),
        .wr_idx    (train_idx),
        .wr_tag    (trn_info),
        .wr_target (trn_target)
    );

    btb_match u_match (
        .pc      (fetch_pc),
        .row     (look_row),
        .next_pc (pred_next)
    );

    always_comb begin
        pred_info = fetch_pc;
    end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ROWS  = 64,
    parameter int SHIFT = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] fetch_pc,
    input logic [31:0] pred_next,
    input logic        trn_valid,
    input logic [31:0] trn_info,
    input logic        trn_correct,
    input logic [31:0] trn_target
);

    localparam int IDX_W = $clog2(ROWS);

    logic any_written;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            any_written <= 1'b0;
        end else if (trn_valid && !trn_correct) begin
            any_written <= 1'b1;
        end
    end

    AST_EMPTY_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        !any_written |-> (pred_next == fetch_pc + 32'd4)); // R1

    AST_WRITE_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && !trn_correct) |=>
            ((fetch_pc != $past(trn_info)) || (pred_next == $past(trn_target)))); // R9

    AST_ALIAS_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        (trn_valid && !trn_correct) |=>
            (!((fetch_pc[SHIFT +: IDX_W] == $past(trn_info[SHIFT +: IDX_W]))
               && (fetch_pc != $past(trn_info)))
             || (pred_next == fetch_pc + 32'd4))); // R3

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(fetch_pc) && !$past(trn_valid && !trn_correct)) |->
            $stable(pred_next)); // R8

endmodule

bind btb_predictor btb_predictor_chk #(.ROWS(ROWS), .SHIFT(SHIFT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_pc    (fetch_pc),
    .pred_next   (pred_next),
    .trn_valid   (trn_valid),
    .trn_info    (trn_info),
    .trn_correct (trn_correct),
    .trn_target  (trn_target)
);

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [31:0] pred_next;
    logic [31:0] pred_info;
    logic        trn_valid = 1'b0;
    logic [31:0] trn_info = '0;
    logic        trn_correct = 1'b0;
    logic [31:0] trn_target = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_valid  [NROWS];
    logic [31:0] m_tag    [NROWS];
    logic [31:0] m_target [NROWS];

    btb_predictor i_btb_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_pc    (fetch_pc),
        .pred_next   (pred_next),
        .pred_info   (pred_info),
        .trn_valid   (trn_valid),
        .trn_info    (trn_info),
        .trn_correct (trn_correct),
        .trn_target  (trn_target)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int row_of(logic [31:0] a);
        return int'(a[7:2]);
    endfunction

    function automatic logic [31:0] expect_next(logic [31:0] a);
        int r = row_of(a);
        if (m_valid[r] && m_tag[r] == a) return m_target[r];
        return a + 32'd4;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check before the rising edge,
    // then update the model at the rising edge.
    task automatic step(string req, logic [31:0] pc, logic tv, logic [31:0] ti,
                        logic tc, logic [31:0] tt);
        fetch_pc    = pc;
        trn_valid   = tv;
        trn_info    = ti;
        trn_correct = tc;
        trn_target  = tt;
        #1;
        check(req, pred_next, expect_next(pc));
        check("R6", pred_info, pc);
        @(posedge clk);
        if (tv && !tc) begin
            m_valid[row_of(ti)]  = 1'b1;
            m_tag[row_of(ti)]    = ti;
            m_target[row_of(ti)] = tt;
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NROWS; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i] = '0;
            m_target[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R5: empty table, sequential prediction, wraparound
        step("R1", 32'h0000_0000, 0, 0, 0, 0);
        step("R1", 32'h0000_0100, 0, 0, 0, 0);
        fetch_pc = 32'hFFFF_FFFC; #1;
        check("R5", pred_next, 32'h0000_0000);
        step("R5", 32'hFFFF_FFFC, 0, 0, 0, 0);

        // R9: train and look up the same address in one cycle -> old value
        fetch_pc = 32'h0000_0100; trn_valid = 1; trn_info = 32'h0000_0100;
        trn_correct = 0; trn_target = 32'h0000_4000; #1;
        check("R9", pred_next, 32'h0000_0104);
        step("R9", 32'h0000_0100, 1, 32'h0000_0100, 0, 32'h0000_4000);
        // R4 / R7: visible next cycle
        fetch_pc = 32'h0000_0100; trn_valid = 0; #1;
        check("R7", pred_next, 32'h0000_4000);
        step("R4", 32'h0000_0100, 0, 0, 0, 0);
        // R3: same row, different tag misses
        fetch_pc = 32'h0000_0200; #1;
        check("R3", pred_next, 32'h0000_0204);
        step("R3", 32'h0000_0200, 0, 0, 0, 0);
        // R2: neighbour row trained, original row intact
        step("R2", 32'h0000_0104, 1, 32'h0000_0104, 0, 32'h0000_5000);
        fetch_pc = 32'h0000_0104; #1;
        check("R2", pred_next, 32'h0000_5000);
        fetch_pc = 32'h0000_0100; #1;
        check("R2", pred_next, 32'h0000_4000);
        // R8: correct feedback must not write
        step("R8", 32'h0000_0100, 1, 32'h0000_0100, 1, 32'h0000_9990);
        fetch_pc = 32'h0000_0100; #1;
        check("R8", pred_next, 32'h0000_4000);
        // R11: trn_valid low must not write
        step("R11", 32'h0000_0100, 0, 32'h0000_0100, 0, 32'h0000_7770);
        fetch_pc = 32'h0000_0100; #1;
        check("R11", pred_next, 32'h0000_4000);
        // R10: alias replaces the entry
        step("R10", 32'h0000_0200, 1, 32'h0000_0200, 0, 32'h0000_6000);
        fetch_pc = 32'h0000_0100; #1;
        check("R10", pred_next, 32'h0000_0104);
        fetch_pc = 32'h0000_0200; #1;
        check("R10", pred_next, 32'h0000_6000);
        step("R10", 32'h0000_0200, 0, 0, 0, 0);

        // Random phase: small pool so rows collide and hits are frequent
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pc;
            logic [31:0] ti;
            pc = {22'($urandom % 3) << 10, 2'b0, 6'($urandom), 2'b00};
            pc[31:10] = 22'($urandom % 3);
            ti = {22'($urandom % 3), 6'($urandom % 8), 4'b0000};
            if (($urandom % 4) == 0) ti = pc;
            step("R4/R5 random", pc, 1'($urandom % 2), ti, 1'($urandom % 3 == 0),
                 $urandom & 32'hFFFF_FFFC);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule